// File: doc/BRIEF.md
# Memory Protection Register File

This block stores the configuration and address registers for a set of memory protection entries and serves software reads and writes to them over a simple register-access port. The port carries an enable, a group select (configuration or address), an index, a write enable and write data. Read data is returned combinationally from the index.

Every write is legalized before it is stored. Reserved permission combinations are cleared, and the four-byte match mode is forbidden when the granule is coarse. Locked entries refuse changes. An address register also refuses changes when the entry above it is locked in top-of-range mode. Address read-back is shaped by the granule exponent `GRAIN` and by the entry's match mode, while the stored value stays unmasked. The stored per-entry configuration and addresses are driven out in flat form to a separate match checker.

Top module: `prot_regs_top`

## Requirements
- R1: After a synchronous reset every configuration byte and every address register is zero (mode off, unlocked), and both reads return zero.
- R2: A configuration byte has the lock flag at bit 7, the match mode at bits 4:3 (off=00, top-of-range=01, four-byte=10, power-of-two=11), execute at bit 2, write at bit 1 and read at bit 0. Bits 6:5 always read zero. Configuration register n holds entry 4n+k at bits 8k+7:8k, with 4 entries per register when XLEN=32 and 8 when XLEN=64.
- R3: A write to the configuration byte of a locked entry leaves that byte unchanged, while the other unlocked bytes in the same register still update.
- R4: A configuration write with read=0 and write=1 stores read, write and execute as 0.
- R5: When GRAIN is at least 1, a written four-byte mode (10) is stored as off (00). When GRAIN is 0 it is kept.
- R6: A write to the address register of a locked entry is ignored.
- R7: A write to the address register of entry e is ignored when entry e+1 is locked and in top-of-range mode. Entry e+1 locked in another mode does not block it. The last entry is blocked only by its own lock.
- R8: With XLEN=64, an accepted address write keeps bits 53:0 and stores zero in bits 63:54.
- R9: Address read-back with mode bit 1 set and GRAIN at least 2 shows the low GRAIN-1 bits as ones. With mode bit 1 clear and GRAIN at least 1 it shows the low GRAIN bits as zeros. Otherwise it shows the stored value.
- R10: A configuration access with an odd index when XLEN=64, or with an index beyond the last configuration register, raises `csr_illegal`, changes no state and reads zero.
- R11: `ent_cfg_o` and `ent_addr_o` carry the stored values of every entry, with no read-back masking. Entry e is at bits 8e+7:8e and at bits XLEN*(e+1)-1:XLEN*e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_en | input | 1 | Access valid this cycle |
| csr_cfg_sel | input | 1 | 1 selects configuration registers, 0 selects address registers |
| csr_idx | input | $clog2(NUM_ENTRIES) | Register index |
| csr_we | input | 1 | Write enable |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data |
| csr_illegal | output | 1 | Illegal configuration index |
| ent_cfg_o | output | 8*NUM_ENTRIES | Stored configuration bytes of all entries |
| ent_addr_o | output | XLEN*NUM_ENTRIES | Stored address registers of all entries |

## Verification
On every cycle the assertions check three kinds of rule. Locked configuration bytes and guarded address registers do not move. Stored configurations never hold a reserved permission pair or a forbidden four-byte mode. Under XLEN=64 the address upper bits stay clear, and illegal accesses leave all state alone. Some behaviour only the bench scenarios can show. These are the byte packing order, per-byte independence within one packed write, and the read-back masks for each mode and granule. The difference between a locked top-of-range neighbour and a locked neighbour in another mode also needs a scenario.

// File: rtl/prot_regs_pkg.sv
package prot_regs_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_TOR   = 2'b01,
        MODE_NA4   = 2'b10,
        MODE_NAPOT = 2'b11
    } match_mode_e;

    typedef struct packed {
        logic        lock;
        logic [1:0]  rsvd;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } ent_cfg_t;

    localparam logic [7:0] CFG_WRITE_MASK = 8'h9f;

    // Apply permission and mode legalization to one written byte.
    function automatic ent_cfg_t legalize_cfg(input logic [7:0] v, input int grain);
        ent_cfg_t c;
        c = ent_cfg_t'(v & CFG_WRITE_MASK);
        if (c.w && !c.r) begin
            c.x = 1'b0;
            c.w = 1'b0;
            c.r = 1'b0;
        end
        if (grain >= 1 && c.mode == MODE_NA4)
            c.mode = MODE_OFF;
        return c;
    endfunction

    // Mask with the low n bits set (n limited to 64).
    function automatic logic [63:0] low_ones(input int n);
        logic [63:0] m;
        for (int i = 0; i < 64; i++)
            m[i] = (i < n);
        return m;
    endfunction

endpackage

// File: rtl/prot_cfg_bank.sv
module prot_cfg_bank
    import prot_regs_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16,
    parameter int GRAIN       = 2,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [XLEN-1:0]                   wr_data,
    output ent_cfg_t [NUM_ENTRIES-1:0]        cfg_q
);
    localparam int EPR = XLEN / 8;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        localparam int LANE   = e % EPR;
        localparam int REG_IX = (e / EPR) * (EPR / 4);

        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(REG_IX));

        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[e] <= '0;
            else if (hit && !cfg_q[e].lock)
                cfg_q[e] <= legalize_cfg(wr_data[LANE*8 +: 8], GRAIN);
        end

        // R3
        cfg_lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
            cfg_q[e].lock |=> $stable(cfg_q[e]));

        // R4
        cfg_no_wonly_chk: assert property (@(posedge clk) disable iff (rst)
            cfg_q[e].w |-> cfg_q[e].r);

        if (GRAIN >= 1) begin : g_na4
            // R5
            cfg_no_na4_chk: assert property (@(posedge clk) disable iff (rst)
                cfg_q[e].mode != MODE_NA4);
        end
    end

endmodule

// File: rtl/prot_addr_bank.sv
module prot_addr_bank #(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [XLEN-1:0]                   wr_data,
    input  logic [NUM_ENTRIES-1:0]            lock_v,
    input  logic [NUM_ENTRIES-1:0]            tor_v,
    output logic [NUM_ENTRIES-1:0][XLEN-1:0]  addr_q
);
    localparam int KEEP_BITS = (XLEN == 64) ? 54 : XLEN;
    localparam logic [XLEN:0] ONE_EXT = 1;
    localparam logic [XLEN-1:0] KEEP_MASK = XLEN'((ONE_EXT << KEEP_BITS) - 1'b1);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        logic guard;
        if (e + 1 < NUM_ENTRIES) begin : g_mid
            assign guard = lock_v[e] || (lock_v[e+1] && tor_v[e+1]);

            // R7
            addr_tor_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (lock_v[e+1] && tor_v[e+1]) |=> $stable(addr_q[e]));
        end else begin : g_last
            assign guard = lock_v[e];
        end

        always_ff @(posedge clk) begin
            if (rst)
                addr_q[e] <= '0;
            else if (wr_en && wr_idx == IDX_W'(e) && !guard)
                addr_q[e] <= wr_data & KEEP_MASK;
        end

        // R6
        addr_lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
            lock_v[e] |=> $stable(addr_q[e]));

        if (XLEN > 54) begin : g_wide
            // R8
            addr_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
                addr_q[e][XLEN-1:54] == '0);
        end
    end

endmodule

// File: rtl/prot_read_mux.sv
module prot_read_mux
    import prot_regs_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16,
    parameter int GRAIN       = 2,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                              cfg_sel,
    input  logic [IDX_W-1:0]                  idx,
    input  ent_cfg_t [NUM_ENTRIES-1:0]        cfg_q,
    input  logic [NUM_ENTRIES-1:0][XLEN-1:0]  addr_q,
    output logic [XLEN-1:0]                   rdata
);
    localparam int EPR = XLEN / 8;
    localparam int EW  = IDX_W + 4;
    localparam logic [63:0] SET_M64 = low_ones(GRAIN >= 2 ? GRAIN - 1 : 0);
    localparam logic [63:0] CLR_M64 = low_ones(GRAIN);
    localparam logic [XLEN-1:0] SET_MASK = SET_M64[XLEN-1:0];
    localparam logic [XLEN-1:0] CLR_MASK = CLR_M64[XLEN-1:0];

    logic [XLEN-1:0] cfg_word;
    logic [XLEN-1:0] addr_word;

    always_comb begin
        logic [EW-1:0] ent_n;
        cfg_word = '0;
        for (int i = 0; i < EPR; i++) begin
            ent_n = EW'(idx) * EW'(4) + EW'(i);
            if (ent_n < EW'(NUM_ENTRIES))
                cfg_word[i*8 +: 8] = cfg_q[ent_n[IDX_W-1:0]];
        end
    end

    always_comb begin
        logic mode_hi;
        mode_hi   = cfg_q[idx].mode[1];
        addr_word = addr_q[idx];
        if (mode_hi && GRAIN >= 2)
            addr_word = addr_word | SET_MASK;
        else if (!mode_hi && GRAIN >= 1)
            addr_word = addr_word & ~CLR_MASK;
    end

    assign rdata = cfg_sel ? cfg_word : addr_word;

endmodule

// File: rtl/prot_regs_top.sv
module prot_regs_top
    import prot_regs_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16,
    parameter int GRAIN       = 2,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          csr_en,
    input  logic                          csr_cfg_sel,
    input  logic [IDX_W-1:0]              csr_idx,
    input  logic                          csr_we,
    input  logic [XLEN-1:0]               csr_wdata,
    output logic [XLEN-1:0]               csr_rdata,
    output logic                          csr_illegal,
    output logic [8*NUM_ENTRIES-1:0]      ent_cfg_o,
    output logic [XLEN*NUM_ENTRIES-1:0]   ent_addr_o
);
    localparam int NUM_CFG_IDX = NUM_ENTRIES / 4;

    ent_cfg_t [NUM_ENTRIES-1:0]       cfg_q;
    logic [NUM_ENTRIES-1:0][XLEN-1:0] addr_q;
    logic [NUM_ENTRIES-1:0]           lock_v;
    logic [NUM_ENTRIES-1:0]           tor_v;
    logic                             cfg_idx_ok;
    logic                             cfg_wr;
    logic                             addr_wr;
    logic [XLEN-1:0]                  mux_rdata;

    assign cfg_idx_ok  = (32'(csr_idx) < NUM_CFG_IDX) && ((XLEN == 32) || !csr_idx[0]);
    assign csr_illegal = csr_en && csr_cfg_sel && !cfg_idx_ok;
    assign cfg_wr      = csr_en && csr_we && csr_cfg_sel && cfg_idx_ok;
    assign addr_wr     = csr_en && csr_we && !csr_cfg_sel;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_flags
        assign lock_v[e] = cfg_q[e].lock;
        assign tor_v[e]  = (cfg_q[e].mode == MODE_TOR);
    end

    prot_cfg_bank #(.XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES), .GRAIN(GRAIN)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_idx(csr_idx),
        .wr_data(csr_wdata), .cfg_q(cfg_q)
    );

    prot_addr_bank #(.XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES)) u_addr (
        .clk(clk), .rst(rst), .wr_en(addr_wr), .wr_idx(csr_idx),
        .wr_data(csr_wdata), .lock_v(lock_v), .tor_v(tor_v), .addr_q(addr_q)
    );

    prot_read_mux #(.XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES), .GRAIN(GRAIN)) u_rd (
        .cfg_sel(csr_cfg_sel), .idx(csr_idx), .cfg_q(cfg_q),
        .addr_q(addr_q), .rdata(mux_rdata)
    );

    assign csr_rdata  = (csr_en && !csr_illegal) ? mux_rdata : '0;
    assign ent_cfg_o  = cfg_q;
    assign ent_addr_o = addr_q;

    // R10
    illegal_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        csr_illegal |=> ($stable(ent_cfg_o) && $stable(ent_addr_o)));

    // R10
    illegal_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        csr_illegal |-> (csr_rdata == '0));

endmodule

// File: tb/prot_regs_top_test.sv
`timescale 1ns/1ps
module prot_regs_top_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    // 32-bit instance, granule exponent 2
    logic        en, cs, we, ill;
    logic [3:0]  idx;
    logic [31:0] wd, rd;
    logic [127:0] cfg_o;
    logic [511:0] addr_o;

    // 64-bit instance, granule exponent 0
    logic        en_w, cs_w, we_w, ill_w;
    logic [3:0]  idx_w;
    logic [63:0] wd_w, rd_w;
    logic [127:0] cfg_ow;
    logic [1023:0] addr_ow;

    prot_regs_top #(.XLEN(32), .NUM_ENTRIES(16), .GRAIN(2)) uut (
        .clk(clk), .rst(rst), .csr_en(en), .csr_cfg_sel(cs), .csr_idx(idx),
        .csr_we(we), .csr_wdata(wd), .csr_rdata(rd), .csr_illegal(ill),
        .ent_cfg_o(cfg_o), .ent_addr_o(addr_o)
    );

    prot_regs_top #(.XLEN(64), .NUM_ENTRIES(16), .GRAIN(0)) uut_w (
        .clk(clk), .rst(rst), .csr_en(en_w), .csr_cfg_sel(cs_w), .csr_idx(idx_w),
        .csr_we(we_w), .csr_wdata(wd_w), .csr_rdata(rd_w), .csr_illegal(ill_w),
        .ent_cfg_o(cfg_ow), .ent_addr_o(addr_ow)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Vector: {we, cfg_sel, idx[3:0], data[31:0], exp[31:0], req[3:0]}
    localparam int NV = 24;
    localparam logic [73:0] VEC [NV] = '{
        {1'b0, 1'b1, 4'd0,  32'h0,        32'h0,        4'd1},  // R1 cfg reset
        {1'b0, 1'b0, 4'd5,  32'h0,        32'h0,        4'd1},  // R1 addr reset
        {1'b1, 1'b1, 4'd0,  32'hFB136607, 32'h0,        4'd4},  // R4 R5 legalized bytes
        {1'b0, 1'b1, 4'd0,  32'h0,        32'h9B030007, 4'd2},  // R2 packing
        {1'b1, 1'b1, 4'd0,  32'h0,        32'h0,        4'd3},  // R3 clear all bytes
        {1'b0, 1'b1, 4'd0,  32'h0,        32'h9B000000, 4'd3},  // R3 locked byte kept
        {1'b1, 1'b0, 4'd3,  32'h1234,     32'h0,        4'd6},  // R6 own lock
        {1'b0, 1'b0, 4'd3,  32'h0,        32'h00000001, 4'd6},  // R6 ignored (napot shows bit0)
        {1'b1, 1'b0, 4'd2,  32'hABCD,     32'h0,        4'd7},  // R7 next locked napot
        {1'b0, 1'b0, 4'd2,  32'h0,        32'h0000ABCC, 4'd7},  // R7 accepted
        {1'b1, 1'b0, 4'd4,  32'h5555,     32'h0,        4'd7},  // R7 setup
        {1'b1, 1'b1, 4'd1,  32'h00008B1B, 32'h0,        4'd7},  // R7 entry5 locked tor
        {1'b0, 1'b1, 4'd1,  32'h0,        32'h00008B1B, 4'd2},  // R2 reg1
        {1'b1, 1'b0, 4'd4,  32'h7777,     32'h0,        4'd7},  // R7 blocked by tor
        {1'b0, 1'b0, 4'd4,  32'h0,        32'h00005555, 4'd7},  // R7 kept
        {1'b1, 1'b0, 4'd5,  32'h100,      32'h0,        4'd6},  // R6 locked tor entry
        {1'b0, 1'b0, 4'd5,  32'h0,        32'h0,        4'd6},  // R6 kept zero
        {1'b1, 1'b0, 4'd6,  32'h103,      32'h0,        4'd9},  // R9 write
        {1'b0, 1'b0, 4'd6,  32'h0,        32'h00000100, 4'd9},  // R9 low bits zero
        {1'b1, 1'b0, 4'd15, 32'hFFFFFFFF, 32'h0,        4'd7},  // R7 last entry
        {1'b0, 1'b0, 4'd15, 32'h0,        32'hFFFFFFFC, 4'd9},  // R9 off mode mask
        {1'b1, 1'b1, 4'd3,  32'h18000000, 32'h0,        4'd9},  // R9 switch to napot
        {1'b0, 1'b0, 4'd15, 32'h0,        32'hFFFFFFFF, 4'd9},  // R9 napot mask
        {1'b0, 1'b1, 4'd3,  32'h0,        32'h18000000, 4'd2}   // R2 reg3
    };

    task automatic acc(input logic w, input logic c, input logic [3:0] i, input logic [31:0] d);
        @(negedge clk);
        en = 1'b1; we = w; cs = c; idx = i; wd = d;
        if (w) begin
            @(negedge clk);
            we = 1'b0;
        end
        #1;
    endtask

    task automatic acc_w(input logic w, input logic c, input logic [3:0] i, input logic [63:0] d);
        @(negedge clk);
        en_w = 1'b1; we_w = w; cs_w = c; idx_w = i; wd_w = d;
        if (w) begin
            @(negedge clk);
            we_w = 1'b0;
        end
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        en = 0; cs = 0; we = 0; idx = 0; wd = 0;
        en_w = 0; cs_w = 0; we_w = 0; idx_w = 0; wd_w = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 outputs", {63'h0, |{cfg_o, addr_o, cfg_ow, addr_ow}}, 64'h0);

        for (int k = 0; k < NV; k++) begin
            acc(VEC[k][73], VEC[k][72], VEC[k][71:68], VEC[k][67:36]);
            if (!VEC[k][73])
                check($sformatf("R%0d vec%0d", VEC[k][3:0], k), {32'h0, rd}, {32'h0, VEC[k][35:4]});
        end

        // R11 stored values unmasked
        check("R11 addr15", {32'h0, addr_o[15*32 +: 32]}, 64'hFFFFFFFF);
        check("R11 addr2", {32'h0, addr_o[2*32 +: 32]}, 64'hABCD);
        check("R11 cfg5", {56'h0, cfg_o[5*8 +: 8]}, 64'h8B);

        // R10 out-of-range cfg index on 32-bit
        acc(1'b1, 1'b1, 4'd4, 32'hFFFFFFFF);
        acc(1'b0, 1'b1, 4'd4, 32'h0);
        check("R10 illegal flag", {63'h0, ill}, 64'h1);
        check("R10 read zero", {32'h0, rd}, 64'h0);
        check("R10 cfg intact", cfg_o[63:0], {32'h00008B1B, 32'h9B000000});

        // 64-bit instance: R5 kept when GRAIN=0, R2 8 per register
        acc_w(1'b1, 1'b1, 4'd0, 64'h0000_0000_0000_1300);
        acc_w(1'b0, 1'b1, 4'd0, 64'h0);
        check("R5 na4 kept g0", rd_w, 64'h1300);
        acc_w(1'b1, 1'b1, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R10 odd illegal", {63'h0, ill_w}, 64'h1);
        check("R10 odd read zero", rd_w, 64'h0);
        acc_w(1'b0, 1'b1, 4'd0, 64'h0);
        check("R10 odd no effect", rd_w, 64'h1300);
        acc_w(1'b1, 1'b1, 4'd2, 64'h0300_0000_0000_0001);
        acc_w(1'b0, 1'b1, 4'd2, 64'h0);
        check("R2 reg2 entries 8-15", rd_w, 64'h0300_0000_0000_0001);
        check("R2 entry15 byte", {56'h0, cfg_ow[15*8 +: 8]}, 64'h03);
        acc_w(1'b1, 1'b0, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        acc_w(1'b0, 1'b0, 4'd1, 64'h0);
        check("R8 R9 addr 54 bits", rd_w, 64'h003F_FFFF_FFFF_FFFF);
        check("R8 stored", addr_ow[1*64 +: 64], 64'h003F_FFFF_FFFF_FFFF);

        // R1 reset again
        @(negedge clk);
        en = 0; en_w = 0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        acc(1'b0, 1'b1, 4'd0, 32'h0);
        check("R1 cfg after reset", {32'h0, rd}, 64'h0);
        check("R1 all cleared", {63'h0, |{cfg_o, addr_o, cfg_ow, addr_ow}}, 64'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule